// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shift Register

This block converts a parallel word into a serial bit stream. A level-sensitive, active-low load input copies the parallel word into a register chain. While load is inactive, each qualified rising edge of a gated shift clock moves the chain one stage toward the last stage. The serial input enters the first stage. The last stage drives a true output and an inverted output.

The shift clock is built from two pins that are treated the same way. Their OR forms the gated clock. Either pin can act as the clock while the other pin is held low. Holding either pin high blocks all shifting. The pins are not used as clocks. A fast system clock samples the two clock pins and the load pin through synchronizer chains. A rising edge of the sampled gated clock is turned into a one-cycle shift strobe. A load that is active in the same cycle as a strobe wins, and the strobe is dropped.

Top module: `gated_piso`

## Requirements
- R1: When load is inactive, a qualified edge shifts the register one stage. Stage 0 takes `ser_i`, and stage k takes the old value of stage k-1.
- R2: While `load_ni` is 0, stage i takes `par_i[i]`. This puts `par_i[WIDTH-1]` on `q_o`.
- R3: A load that is active in the same cycle as a gated-clock edge takes priority. The edge is discarded, and the serial input has no effect.
- R4: While load is inactive and no gated-clock rising edge occurs, every stage keeps its value. This includes toggling one clock pin while the other is held high.
- R5: Either clock pin shifts the register on its rising edge while the other pin is held low.
- R6: `q_o` equals the last stage, and `qn_o` is always its inverse.
- R7: While `rst_ni` is 0 at a system clock edge, all stages clear, so `q_o` is 0 and `qn_o` is 1. Releasing reset with a clock pin already high causes no shift.
- R8: A change on a clock pin or on the load pin reaches the register on the (SYNC_STAGES+1)-th system clock edge after it. With the default setting this is the 3rd edge, and it is not visible after the 2nd edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ck_a_i | input | 1 | Shift clock pin A, OR-combined with B |
| ck_b_i | input | 1 | Shift clock pin B, OR-combined with A |
| load_ni | input | 1 | Active-low level parallel load |
| par_i | input | WIDTH | Parallel data, bit i goes to stage i |
| ser_i | input | 1 | Serial data into stage 0 |
| q_o | output | 1 | Last stage, true |
| qn_o | output | 1 | Last stage, inverted |

## Verification
The bench builds the block with WIDTH=8 and SYNC_STAGES=2. With these values the whole register can be read out through `q_o` within eight shifts after any load. The three-edge latency of R8 can also be checked cycle by cycle, at exactly the edge where the output changes. Random loads, shifts through either pin, inhibited toggles and load-versus-edge collisions are compared against a software model of the eight stages. Directed cases cover reset release with a pin held high and a load that coincides with an edge.

// File: rtl/piso_pkg.sv
package piso_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } piso_op_e;

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int             N      = 3,
    parameter int             STAGES = 2,
    parameter logic [N-1:0]   RST_V  = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);

    typedef struct packed {
        logic [STAGES-1:0][N-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) begin
                st_q.chain[s] <= RST_V;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/piso_edge.sv
module piso_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic a_i,
    input  logic b_i,
    output logic rise_o
);

    typedef struct packed {
        logic gate;
    } edge_t;

    edge_t st_d, st_q;
    logic  gate;

    always_comb begin
        gate      = a_i | b_i;
        st_d      = st_q;
        st_d.gate = gate;
        rise_o    = gate & ~st_q.gate;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.gate <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R4/R5: a pin held high for two samples blocks any strobe
    a_r4_inhibit_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((b_i && $past(b_i)) || (a_i && $past(a_i))) |-> !rise_o);

endmodule

// File: rtl/piso_shift.sv
module piso_shift
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] regs_o
);

    typedef struct packed {
        logic [WIDTH-1:0] regs;
    } core_t;

    core_t    st_d, st_q;
    piso_op_e op;

    always_comb begin
        if (load_i) begin
            op = OP_LOAD;
        end else if (step_i) begin
            op = OP_SHIFT;
        end else begin
            op = OP_HOLD;
        end
        st_d = st_q;
        unique case (op)
            OP_LOAD:  st_d.regs = par_i;
            OP_SHIFT: st_d.regs = {st_q.regs[WIDTH-2:0], ser_i};
            default:  st_d.regs = st_q.regs;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.regs <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.regs;

    // R2/R3: load wins regardless of strobe and serial input
    a_r2_load_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (regs_o == $past(par_i)));

    // R1: shift direction, stage 0 takes serial input
    a_r1_shift_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !load_i) |=> (regs_o == {$past(regs_o[WIDTH-2:0]), $past(ser_i)}));

    // R4: no load and no strobe keeps every stage
    a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !load_i) |=> $stable(regs_o));

    // R7: leaving reset finds all stages cleared
    a_r7_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (regs_o == '0));

endmodule

// File: rtl/gated_piso.sv
module gated_piso
    import piso_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ck_a_i,
    input  logic             ck_b_i,
    input  logic             load_ni,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    output logic             q_o,
    output logic             qn_o
);

    localparam int         NSYNC   = 3;
    localparam logic [2:0] SYNC_RV = 3'b111;

    logic [NSYNC-1:0] raw, synced;
    logic             step;
    logic             load_act;
    logic [WIDTH-1:0] regs;

    assign raw = {load_ni, ck_b_i, ck_a_i};

    piso_sync #(
        .N      (NSYNC),
        .STAGES (SYNC_STAGES),
        .RST_V  (SYNC_RV)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw),
        .q_o    (synced)
    );

    piso_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .a_i    (synced[0]),
        .b_i    (synced[1]),
        .rise_o (step)
    );

    assign load_act = ~synced[2];

    piso_shift #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load_act),
        .step_i (step),
        .par_i  (par_i),
        .ser_i  (ser_i),
        .regs_o (regs)
    );

    assign q_o  = regs[WIDTH-1];
    assign qn_o = ~regs[WIDTH-1];

    // R6: complementary outputs seen at the ports
    a_r6_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
        qn_o != q_o);

endmodule

// File: tb/tb_gated_piso.sv
module tb_gated_piso;

    localparam int W   = 8;
    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ck_a = 1'b0, ck_b = 1'b0, load_n = 1'b1, ser = 1'b0;
    logic [W-1:0] par = '0;
    logic         q, qn;

    logic [W-1:0] model = '0;
    int           n_chk = 0, n_bad = 0;
    int unsigned  seed = 32'd7;

    always #4 clk = ~clk;

    gated_piso #(.WIDTH(W), .SYNC_STAGES(2)) dut (
        .clk_i(clk), .rst_ni(rst_n), .ck_a_i(ck_a), .ck_b_i(ck_b),
        .load_ni(load_n), .par_i(par), .ser_i(ser), .q_o(q), .qn_o(qn)
    );

    function automatic logic [W-1:0] f_shift(logic [W-1:0] r, logic s);
        return {r[W-2:0], s};
    endfunction

    task automatic wait_edges(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req);
        n_chk++;
        if (q !== model[W-1] || qn !== ~model[W-1]) begin
            n_bad++;
            $display("FAIL %s: q=%b qn=%b expected q=%b qn=%b",
                     req, q, qn, model[W-1], ~model[W-1]);
        end
    endtask

    task automatic do_load(logic [W-1:0] v);
        par = v; load_n = 1'b0;
        wait_edges(LAT + 2);
        model = v;
        check("R2 load");
        load_n = 1'b1;
        wait_edges(LAT + 2);
        check("R4 after load release");
    endtask

    task automatic pulse(bit use_b, logic s);
        ser = s;
        if (use_b) ck_b = 1'b1; else ck_a = 1'b1;
        wait_edges(LAT + 2);
        model = f_shift(model, s);
        check(use_b ? "R5 shift via pin B" : "R1 shift via pin A");
        if (use_b) ck_b = 1'b0; else ck_a = 1'b0;
        wait_edges(LAT + 2);
        check("R4 falling pin holds");
    endtask

    task automatic inhibited(logic s, int n);
        ser = s;
        ck_a = 1'b1;
        wait_edges(LAT + 2);
        model = f_shift(model, s);
        check("R5 edge before inhibit");
        ck_b = 1'b1;
        wait_edges(LAT + 2);
        for (int k = 0; k < n; k++) begin
            ser = ~ser;
            ck_a = 1'b0; wait_edges(2);
            ck_a = 1'b1; wait_edges(2);
        end
        wait_edges(LAT + 2);
        check("R4 inhibited toggles");
        ck_b = 1'b0;
        wait_edges(LAT + 2);
        check("R4 inhibit drop while clock high");
        ck_a = 1'b0;
        wait_edges(LAT + 2);
        check("R4 clock low after inhibit");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(seed));
        ck_a = 1'b1;
        wait_edges(3);
        rst_n = 1'b1;
        wait_edges(LAT + 2);
        check("R7 reset state, no shift with pin high");
        ck_a = 1'b0;
        wait_edges(LAT + 2);
        check("R7 idle after reset");

        do_load(8'hA5);
        for (int i = 0; i < W; i++) pulse(i[0], 1'b0);
        check("R1 register drained");

        do_load(8'h80);
        ser = 1'b1; ck_a = 1'b1;
        wait_edges(LAT - 1);
        check("R8 not yet after 2 edges");
        wait_edges(1);
        model = f_shift(model, 1'b1);
        check("R8 shift on 3rd edge");
        ck_a = 1'b0;
        wait_edges(LAT + 2);

        par = 8'h81; ser = 1'b0; load_n = 1'b0; ck_b = 1'b1;
        wait_edges(LAT + 2);
        model = 8'h81;
        check("R3 load beats coincident edge");
        load_n = 1'b1;
        wait_edges(LAT + 2);
        check("R3 edge discarded");
        ck_b = 1'b0;
        wait_edges(LAT + 2);
        check("R6 complement after collision");

        do_load(8'h7F);
        inhibited(1'b1, 4);

        for (int it = 0; it < 250; it++) begin
            int op;
            op = int'($urandom_range(0, 3));
            case (op)
                0: do_load(W'($urandom));
                1: pulse(1'b0, 1'($urandom));
                2: pulse(1'b1, 1'($urandom));
                default: inhibited(1'($urandom), int'($urandom_range(1, 3)));
            endcase
        end

        rst_n = 1'b0;
        wait_edges(2);
        model = '0;
        check("R7 reset clears");
        rst_n = 1'b1;
        wait_edges(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule